// File: doc/BRIEF.md
# Atomic Register/Memory Swap Unit

This unit carries out the exchange instruction of a small integer core. It receives an opcode byte that has already been fetched, an optional ModRM byte, and an operand-size mode (16 or 32 bit). It then swaps two register operands, or swaps a register operand with a memory operand.

Registers are reached through two combinational read ports and two byte-lane-masked write ports of the core's register file. Memory is reached through a simple request/acknowledge bus that has a lock output. A memory swap is one locked, indivisible read-then-write pair, so the unit can serve as the primitive for semaphores. No status flags exist in the unit and none are touched.

Each exchange begins with a one-cycle start request. It ends with a one-cycle done pulse, and that pulse is the cycle in which the register file is written. The address of a memory operand arrives fully computed on an input.

Top module: `xchg_unit`

## Requirements
- R1: Opcodes 0x90 to 0x97 swap register 0 (the accumulator) with the register named by opcode bits [2:0]. With op32_i=0 the swap covers bits [15:0] only and bits [31:16] of both registers are kept; with op32_i=1 it covers 32 bits. done_o is high in the cycle right after the start cycle (2 clocks in total).
- R2: Opcode 0x86 takes a ModRM byte and swaps byte operands. The reg field is bits [5:3] and the rm field is bits [2:0]. Byte index 0 to 3 is bits [7:0] of register 0 to 3; byte index 4 to 7 is bits [15:8] of register 0 to 3.
- R3: Opcode 0x87 takes a ModRM byte and swaps 16-bit (op32_i=0) or 32-bit (op32_i=1) operands, using full register indices.
- R4: ModRM bits [7:6] equal to 3 select a register/register swap, with done_o two cycles after the start cycle (3 clocks). Any other value swaps the reg-field register with memory at eff_addr_i.
- R5: A memory swap first reads the operand, then writes the old register value to the same address, and then loads the old memory value into the register. The register write and done_o fall in the cycle in which the write is acknowledged. A request is held, with a stable address, until mem_ack_i.
- R6: mem_lock_o is high in every cycle from the read request through the cycle of the write acknowledge. It is low in the cycle after that, whether or not any lock prefix was present.
- R7: A swap of an operand with itself (0x90, or 0x86/0x87 with mod=3 and reg=rm) writes no register and keeps its normal length; for 0x90 that is 2 clocks.
- R8: start_i is ignored while busy_o is high. An opcode other than 0x86, 0x87 or 0x90 to 0x97 is ignored: busy_o stays low and done_o does not rise.
- R9: done_o is a single-cycle pulse, and register write enables are high only in a done_o cycle.
- R10: Register write lane masks are 0001 for a low byte, 0010 for a high byte, 0011 for 16 bits and 1111 for 32 bits, with write data aligned to those lanes. mem_size_o is 0 for a byte, 1 for 16 bits and 2 for 32 bits. Memory data is right-justified.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Begin an exchange (sampled while idle) |
| opcode_i | input | 8 | Opcode byte |
| modrm_i | input | 8 | ModRM byte (unused by the short form) |
| op32_i | input | 1 | 1 = 32-bit operand size, 0 = 16-bit |
| eff_addr_i | input | ADDR_W | Effective address of a memory operand |
| busy_o | output | 1 | An exchange is in progress |
| done_o | output | 1 | Completion pulse |
| rf_raddr0_o | output | 3 | Read index, reg operand |
| rf_rdata0_i | input | 32 | Read data, reg operand |
| rf_raddr1_o | output | 3 | Read index, second operand |
| rf_rdata1_i | input | 32 | Read data, second operand |
| rf_we0_o | output | 1 | Write enable, reg operand |
| rf_waddr0_o | output | 3 | Write index, reg operand |
| rf_wbe0_o | output | 4 | Byte-lane mask, reg operand |
| rf_wdata0_o | output | 32 | Lane-aligned write data, reg operand |
| rf_we1_o | output | 1 | Write enable, second operand |
| rf_waddr1_o | output | 3 | Write index, second operand |
| rf_wbe1_o | output | 4 | Byte-lane mask, second operand |
| rf_wdata1_o | output | 32 | Lane-aligned write data, second operand |
| mem_req_o | output | 1 | Memory request |
| mem_we_o | output | 1 | 1 = write, 0 = read |
| mem_lock_o | output | 1 | Bus lock |
| mem_size_o | output | 2 | Access size code |
| mem_addr_o | output | ADDR_W | Access address |
| mem_wdata_o | output | 32 | Right-justified write data |
| mem_ack_i | input | 1 | Request accepted / read data valid |
| mem_rdata_i | input | 32 | Right-justified read data |

## Verification
The bench aims at the high-byte register forms, above all a swap of a register's bits [15:8] with its own bits [7:0]. A design with a wrong lane shift or mask there would corrupt the other byte, or leave one lane with a stale value. It checks that lock stays up across memory acknowledge delays of zero to two cycles and drops only after the write is acknowledged; a design that released it between read and write would show lock low while a request is pending. It also checks self-swaps and the 0x90 no-operation for absent write enables and exact cycle counts. Finally, it raises a start during a memory swap, which a design that did not guard its idle state would execute as a second, unwanted exchange.

// File: rtl/xchg_pkg.sv
package xchg_pkg;

  localparam int WORD_W    = 32;
  localparam int LANES     = WORD_W / 8;
  localparam int REG_IDX_W = 3;
  localparam int NPORTS    = 2;

  typedef enum logic [1:0] {
    SZ_BYTE  = 2'd0,
    SZ_WORD  = 2'd1,
    SZ_DWORD = 2'd2
  } opsz_e;

  typedef enum logic [1:0] {
    OPK_NONE = 2'd0,
    OPK_ACC  = 2'd1,
    OPK_REG  = 2'd2,
    OPK_MEM  = 2'd3
  } opkind_e;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_ACC  = 3'd1,
    ST_RRD  = 3'd2,
    ST_RWR  = 3'd3,
    ST_MRD  = 3'd4,
    ST_MWR  = 3'd5
  } xstate_e;

  typedef struct packed {
    opkind_e               kind;
    opsz_e                 size;
    logic [REG_IDX_W-1:0]  reg_idx;
    logic [REG_IDX_W-1:0]  rm_idx;
    logic                  self_swap;
  } xdec_t;

  function automatic logic [WORD_W-1:0] fit_size(input logic [WORD_W-1:0] v,
                                                 input opsz_e s);
    case (s)
      SZ_BYTE: return {{(WORD_W-8){1'b0}}, v[7:0]};
      SZ_WORD: return {{(WORD_W-16){1'b0}}, v[15:0]};
      default: return v;
    endcase
  endfunction

endpackage

// File: rtl/xchg_rst_sync.sv
module xchg_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_n = sync_q[1];

endmodule

// File: rtl/xchg_decode.sv
module xchg_decode
  import xchg_pkg::*;
(
  input  logic [7:0] opcode_i,
  input  logic [7:0] modrm_i,
  input  logic       op32_i,
  output xdec_t      dec_o
);

  logic  is_short;
  logic  is_modrm;
  opsz_e wide_sz;

  assign is_short = (opcode_i[7:3] == 5'b10010);
  assign is_modrm = (opcode_i[7:1] == 7'b1000011);
  assign wide_sz  = op32_i ? SZ_DWORD : SZ_WORD;

  always_comb begin
    dec_o = '0;
    dec_o.kind = OPK_NONE;
    dec_o.size = SZ_BYTE;
    if (is_short) begin
      dec_o.kind      = OPK_ACC;
      dec_o.size      = wide_sz;
      dec_o.reg_idx   = '0;
      dec_o.rm_idx    = opcode_i[2:0];
      dec_o.self_swap = (opcode_i[2:0] == 3'd0);
    end else if (is_modrm) begin
      dec_o.kind      = (modrm_i[7:6] == 2'b11) ? OPK_REG : OPK_MEM;
      dec_o.size      = opcode_i[0] ? wide_sz : SZ_BYTE;
      dec_o.reg_idx   = modrm_i[5:3];
      dec_o.rm_idx    = modrm_i[2:0];
      dec_o.self_swap = (modrm_i[7:6] == 2'b11) && (modrm_i[5:3] == modrm_i[2:0]);
    end
  end

endmodule

// File: rtl/xchg_lane.sv
module xchg_lane
  import xchg_pkg::*;
(
  input  opsz_e                 size_i,
  input  logic [REG_IDX_W-1:0]  idx_i,
  input  logic [WORD_W-1:0]     raw_i,
  input  logic [WORD_W-1:0]     val_i,
  output logic [REG_IDX_W-1:0]  phys_o,
  output logic [WORD_W-1:0]     ext_o,
  output logic [WORD_W-1:0]     wdata_o,
  output logic [LANES-1:0]      be_o
);

  logic hib;

  assign hib    = (size_i == SZ_BYTE) && idx_i[REG_IDX_W-1];
  assign phys_o = (size_i == SZ_BYTE) ? {1'b0, idx_i[REG_IDX_W-2:0]} : idx_i;
  assign ext_o  = hib ? fit_size(raw_i >> 8, SZ_BYTE) : fit_size(raw_i, size_i);

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    if (i == 0) begin : g_low
      assign wdata_o[7:0] = hib ? 8'h00 : val_i[7:0];
    end else begin : g_up
      assign wdata_o[8*i +: 8] = hib ? val_i[8*(i-1) +: 8] : val_i[8*i +: 8];
    end
    assign be_o[i] = (size_i == SZ_DWORD)
                   | ((size_i == SZ_WORD) & (i < 2))
                   | ((size_i == SZ_BYTE) & (hib ? (i == 1) : (i == 0)));
  end

endmodule

// File: rtl/xchg_fsm.sv
module xchg_fsm
  import xchg_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    start_i,
  input  opkind_e kind_i,
  input  logic    mem_ack_i,
  output xstate_e state_o,
  output logic    accept_o
);

  xstate_e st_q, st_d;

  assign accept_o = (st_q == ST_IDLE) && start_i && (kind_i != OPK_NONE);

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE: begin
        if (accept_o) begin
          unique case (kind_i)
            OPK_ACC: st_d = ST_ACC;
            OPK_REG: st_d = ST_RRD;
            OPK_MEM: st_d = ST_MRD;
            default: st_d = ST_IDLE;
          endcase
        end
      end
      ST_ACC:  st_d = ST_IDLE;
      ST_RRD:  st_d = ST_RWR;
      ST_RWR:  st_d = ST_IDLE;
      ST_MRD:  if (mem_ack_i) st_d = ST_MWR;
      ST_MWR:  if (mem_ack_i) st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= ST_IDLE;
    else        st_q <= st_d;
  end

  assign state_o = st_q;

endmodule

// File: rtl/xchg_unit.sv
module xchg_unit
  import xchg_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [7:0]        opcode_i,
  input  logic [7:0]        modrm_i,
  input  logic              op32_i,
  input  logic [ADDR_W-1:0] eff_addr_i,
  output logic              busy_o,
  output logic              done_o,
  output logic [2:0]        rf_raddr0_o,
  input  logic [31:0]       rf_rdata0_i,
  output logic [2:0]        rf_raddr1_o,
  input  logic [31:0]       rf_rdata1_i,
  output logic              rf_we0_o,
  output logic [2:0]        rf_waddr0_o,
  output logic [3:0]        rf_wbe0_o,
  output logic [31:0]       rf_wdata0_o,
  output logic              rf_we1_o,
  output logic [2:0]        rf_waddr1_o,
  output logic [3:0]        rf_wbe1_o,
  output logic [31:0]       rf_wdata1_o,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic              mem_lock_o,
  output logic [1:0]        mem_size_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [31:0]       mem_wdata_o,
  input  logic              mem_ack_i,
  input  logic [31:0]       mem_rdata_i
);

  logic    rst_sync_n;
  xdec_t   dec_w, dec_q;
  xstate_e st;
  logic    accept;

  logic [REG_IDX_W-1:0] lane_idx  [NPORTS];
  logic [REG_IDX_W-1:0] lane_phys [NPORTS];
  logic [WORD_W-1:0]    lane_raw  [NPORTS];
  logic [WORD_W-1:0]    lane_val  [NPORTS];
  logic [WORD_W-1:0]    lane_ext  [NPORTS];
  logic [WORD_W-1:0]    lane_wd   [NPORTS];
  logic [LANES-1:0]     lane_be   [NPORTS];

  logic [ADDR_W-1:0] addr_q;
  logic [WORD_W-1:0] opnd_reg_q, opnd_reg_d;
  logic [WORD_W-1:0] opnd_rm_q, opnd_rm_d;
  logic dec_en, reg_cap_en, rm_cap_en;
  logic in_acc, in_rwr, in_mrd, in_mwr;
  logic finish, wr_allow;

  xchg_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  xchg_decode u_dec (
    .opcode_i (opcode_i),
    .modrm_i  (modrm_i),
    .op32_i   (op32_i),
    .dec_o    (dec_w)
  );

  xchg_fsm u_fsm (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .start_i   (start_i),
    .kind_i    (dec_w.kind),
    .mem_ack_i (mem_ack_i),
    .state_o   (st),
    .accept_o  (accept)
  );

  assign in_acc = (st == ST_ACC);
  assign in_rwr = (st == ST_RWR);
  assign in_mrd = (st == ST_MRD);
  assign in_mwr = (st == ST_MWR);

  // Operand lanes: port 0 serves the reg operand, port 1 the other operand
  assign lane_idx[0] = dec_q.reg_idx;
  assign lane_idx[1] = dec_q.rm_idx;
  assign lane_raw[0] = rf_rdata0_i;
  assign lane_raw[1] = rf_rdata1_i;
  assign lane_val[0] = in_acc ? lane_ext[1] : opnd_rm_q;
  assign lane_val[1] = in_acc ? lane_ext[0] : opnd_reg_q;

  for (genvar p = 0; p < NPORTS; p++) begin : g_port
    xchg_lane u_lane (
      .size_i  (dec_q.size),
      .idx_i   (lane_idx[p]),
      .raw_i   (lane_raw[p]),
      .val_i   (lane_val[p]),
      .phys_o  (lane_phys[p]),
      .ext_o   (lane_ext[p]),
      .wdata_o (lane_wd[p]),
      .be_o    (lane_be[p])
    );
  end

  // Clock enables and next values of the datapath registers
  assign dec_en     = accept;
  assign reg_cap_en = (st == ST_RRD) || in_mrd;
  assign rm_cap_en  = (st == ST_RRD) || (in_mrd && mem_ack_i);

  always_comb begin
    opnd_reg_d = lane_ext[0];
    opnd_rm_d  = (st == ST_RRD) ? lane_ext[1] : fit_size(mem_rdata_i, dec_q.size);
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      dec_q      <= '0;
      addr_q     <= '0;
      opnd_reg_q <= '0;
      opnd_rm_q  <= '0;
    end else begin
      if (dec_en) begin
        dec_q  <= dec_w;
        addr_q <= eff_addr_i;
      end
      if (reg_cap_en) opnd_reg_q <= opnd_reg_d;
      if (rm_cap_en)  opnd_rm_q  <= opnd_rm_d;
    end
  end

  // Completion and register file writes
  assign finish   = in_acc || in_rwr || (in_mwr && mem_ack_i);
  assign wr_allow = !dec_q.self_swap;

  assign busy_o      = (st != ST_IDLE);
  assign done_o      = finish;
  assign rf_raddr0_o = lane_phys[0];
  assign rf_raddr1_o = lane_phys[1];
  assign rf_we0_o    = finish && wr_allow;
  assign rf_waddr0_o = lane_phys[0];
  assign rf_wbe0_o   = lane_be[0];
  assign rf_wdata0_o = lane_wd[0];
  assign rf_we1_o    = (in_acc || in_rwr) && wr_allow;
  assign rf_waddr1_o = lane_phys[1];
  assign rf_wbe1_o   = lane_be[1];
  assign rf_wdata1_o = lane_wd[1];

  // Locked memory read/write pair
  assign mem_req_o   = in_mrd || in_mwr;
  assign mem_we_o    = in_mwr;
  assign mem_lock_o  = in_mrd || in_mwr;
  assign mem_size_o  = dec_q.size;
  assign mem_addr_o  = addr_q;
  assign mem_wdata_o = opnd_reg_q;

endmodule

// File: rtl/xchg_unit_chk.sv
module xchg_unit_chk #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start_i,
  input logic              busy_o,
  input logic              done_o,
  input logic              rf_we0_o,
  input logic              rf_we1_o,
  input logic              mem_req_o,
  input logic              mem_we_o,
  input logic              mem_lock_o,
  input logic              mem_ack_i,
  input logic [ADDR_W-1:0] mem_addr_o
);

  assert_req_locked_R6: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_o |-> mem_lock_o);

  assert_lock_held_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_lock_o && !(mem_req_o && mem_we_o && mem_ack_i)) |=> mem_lock_o);

  assert_lock_release_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_o && mem_we_o && mem_ack_i) |=> !mem_lock_o);

  assert_write_follows_read_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_req_o && mem_we_o) |-> $past(mem_req_o && !mem_we_o && mem_ack_i));

  assert_req_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_o && !mem_ack_i) |=> (mem_req_o && $stable(mem_addr_o) && $stable(mem_we_o)));

  assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  assert_write_in_done_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (rf_we0_o || rf_we1_o) |-> done_o);

  assert_no_spurious_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_o && !start_i) |=> !done_o);

endmodule

bind xchg_unit xchg_unit_chk #(.ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/xchg_unit_tb.sv
module xchg_unit_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W     = 32;
  localparam int WATCHDOG   = 150000;

  logic              clk;
  logic              rst_n;
  logic              start_i;
  logic [7:0]        opcode_i;
  logic [7:0]        modrm_i;
  logic              op32_i;
  logic [ADDR_W-1:0] eff_addr_i;
  logic              busy_o, done_o;
  logic [2:0]        rf_raddr0_o, rf_raddr1_o, rf_waddr0_o, rf_waddr1_o;
  logic [31:0]       rf_rdata0_i, rf_rdata1_i, rf_wdata0_o, rf_wdata1_o;
  logic              rf_we0_o, rf_we1_o;
  logic [3:0]        rf_wbe0_o, rf_wbe1_o;
  logic              mem_req_o, mem_we_o, mem_lock_o, mem_ack_i;
  logic [1:0]        mem_size_o;
  logic [ADDR_W-1:0] mem_addr_o;
  logic [31:0]       mem_wdata_o, mem_rdata_i;

  int checks;
  int errors;

  logic [31:0] rf [8];
  logic [7:0]  mem [64];
  logic        ld;
  logic [2:0]  ld_idx;
  logic [31:0] ld_val;
  bit          rand_ack;
  int          ack_wait;

  xchg_unit #(.ADDR_W(ADDR_W)) dut_i (.*);

  initial begin
    clk = 1'b0;
    forever #(CLK_PERIOD/2) clk = ~clk;
  end

  // Register file model: combinational reads, lane-masked writes at the edge
  assign rf_rdata0_i = rf[rf_raddr0_o];
  assign rf_rdata1_i = rf[rf_raddr1_o];

  always @(posedge clk) begin
    if (ld) rf[ld_idx] <= ld_val;
    else begin
      for (int l = 0; l < 4; l++) begin
        if (rf_we0_o && rf_wbe0_o[l]) rf[rf_waddr0_o][8*l +: 8] <= rf_wdata0_o[8*l +: 8];
        if (rf_we1_o && rf_wbe1_o[l] && !(rf_we0_o && rf_wbe0_o[l] && rf_waddr0_o == rf_waddr1_o))
          rf[rf_waddr1_o][8*l +: 8] <= rf_wdata1_o[8*l +: 8];
      end
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // Memory responder: acts just after each rising edge
  always @(posedge clk) begin
    #1;
    mem_ack_i = 1'b0;
    if (mem_req_o) begin
      chk(mem_lock_o, "R6", "lock during request", {31'd0, mem_lock_o}, 32'd1);
      if (ack_wait == 0) begin
        int n;
        int a;
        logic [31:0] rd;
        n  = (mem_size_o == 2'd0) ? 1 : (mem_size_o == 2'd1) ? 2 : 4;
        a  = int'(mem_addr_o[5:0]);
        rd = '0;
        mem_ack_i = 1'b1;
        for (int b = 0; b < n; b++) begin
          if (mem_we_o) mem[(a + b) % 64] = mem_wdata_o[8*b +: 8];
          else          rd[8*b +: 8] = mem[(a + b) % 64];
        end
        if (!mem_we_o) mem_rdata_i = rd;
        ack_wait = rand_ack ? int'($urandom % 3) : 0;
      end else begin
        ack_wait--;
      end
    end
  end

  function automatic logic [31:0] pick(input logic [31:0] word, input int w, input logic hib);
    if (w == 8)  return hib ? {24'h0, word[15:8]} : {24'h0, word[7:0]};
    if (w == 16) return {16'h0, word[15:0]};
    return word;
  endfunction

  function automatic logic [31:0] place(input logic [31:0] word, input logic [31:0] v,
                                        input int w, input logic hib);
    if (w == 8)  return hib ? {word[31:16], v[7:0], word[7:0]} : {word[31:8], v[7:0]};
    if (w == 16) return {word[31:16], v[15:0]};
    return v;
  endfunction

  function automatic logic [3:0] lane_mask(input int w, input logic hib);
    if (w == 8)  return hib ? 4'b0010 : 4'b0001;
    if (w == 16) return 4'b0011;
    return 4'b1111;
  endfunction

  task automatic load_reg(input logic [2:0] idx, input logic [31:0] val);
    @(negedge clk);
    ld = 1'b1; ld_idx = idx; ld_val = val;
    @(negedge clk);
    ld = 1'b0;
  endtask

  // kind: 1 accumulator form, 2 reg/reg, 3 memory
  task automatic run_op(input logic [7:0] opc, input logic [7:0] mrm, input logic o32,
                        input logic [5:0] ea, input bit intr);
    int w, kind, cyc, n;
    logic [2:0] ra, rb, pa, pb;
    logic ha, hb, selfs, lock_ok, we0s, we1s;
    logic [31:0] va, vb, vm, adrs;
    logic [3:0] be0s;
    logic [1:0] szs;
    logic [31:0] exp_rf [8];
    logic [7:0]  exp_mem [64];
    string rq;

    if (opc[7:3] == 5'b10010) begin
      kind = 1; w = o32 ? 32 : 16; ra = 3'd0; rb = opc[2:0]; selfs = (rb == 3'd0);
      rq = selfs ? "R7" : "R1";
    end else begin
      w = opc[0] ? (o32 ? 32 : 16) : 8;
      ra = mrm[5:3]; rb = mrm[2:0];
      kind = (mrm[7:6] == 2'b11) ? 2 : 3;
      selfs = (kind == 2) && (ra == rb);
      rq = (kind == 3) ? "R5" : selfs ? "R7" : (w == 8) ? "R2" : "R3";
    end
    ha = (w == 8) && ra[2]; hb = (w == 8) && rb[2];
    pa = (w == 8) ? {1'b0, ra[1:0]} : ra;
    pb = (w == 8) ? {1'b0, rb[1:0]} : rb;
    n  = w / 8;
    for (int i = 0; i < 8; i++)  exp_rf[i] = rf[i];
    for (int i = 0; i < 64; i++) exp_mem[i] = mem[i];
    va = pick(rf[pa], w, ha);
    if (kind != 3) begin
      vb = pick(rf[pb], w, hb);
      exp_rf[pa] = place(exp_rf[pa], vb, w, ha);
      exp_rf[pb] = place(exp_rf[pb], va, w, hb);
    end else begin
      vm = '0;
      for (int b = 0; b < n; b++) vm[8*b +: 8] = mem[(int'(ea) + b) % 64];
      exp_rf[pa] = place(exp_rf[pa], vm, w, ha);
      for (int b = 0; b < n; b++) exp_mem[(int'(ea) + b) % 64] = va[8*b +: 8];
    end

    @(negedge clk);
    start_i = 1'b1; opcode_i = opc; modrm_i = mrm; op32_i = o32;
    eff_addr_i = {{(ADDR_W-6){1'b0}}, ea};
    @(negedge clk);
    start_i = 1'b0;
    cyc = 1; lock_ok = 1'b1;
    while (!done_o && cyc < 40) begin
      if (kind == 3 && !mem_lock_o) lock_ok = 1'b0;
      if (intr && cyc == 1) begin start_i = 1'b1; opcode_i = 8'h93; op32_i = 1'b1; end
      else start_i = 1'b0;
      @(negedge clk);
      cyc++;
    end
    chk(done_o, rq, "done seen", {31'd0, done_o}, 32'd1);
    if (kind == 3 && !mem_lock_o) lock_ok = 1'b0;
    we0s = rf_we0_o; we1s = rf_we1_o; be0s = rf_wbe0_o; szs = mem_size_o; adrs = mem_addr_o;
    start_i = 1'b0;

    if (kind == 1)      chk(cyc == 1, rq, "acc form latency", cyc, 1);
    else if (kind == 2) chk(cyc == 2, "R4", "reg form latency", cyc, 2);
    else begin
      chk(cyc >= 2, "R5", "memory form latency", cyc, 2);
      chk(lock_ok, "R6", "lock through exchange", {31'd0, lock_ok}, 32'd1);
      chk(adrs == {26'd0, ea}, "R4", "memory address", adrs, {26'd0, ea});
      chk(szs == ((w == 8) ? 2'd0 : (w == 16) ? 2'd1 : 2'd2), "R10", "mem size code",
          {30'd0, szs}, (w == 8) ? 32'd0 : (w == 16) ? 32'd1 : 32'd2);
    end
    if (selfs) chk(!we0s && !we1s, "R7", "self swap writes nothing", {30'd0, we0s, we1s}, 32'd0);
    else begin
      chk(we0s, rq, "reg write enable", {31'd0, we0s}, 32'd1);
      chk(be0s == lane_mask(w, ha), "R10", "reg lane mask", {28'd0, be0s}, {28'd0, lane_mask(w, ha)});
    end

    @(negedge clk);
    chk(!done_o, "R9", "done single pulse", {31'd0, done_o}, 32'd0);
    chk(!busy_o, rq, "idle after done", {31'd0, busy_o}, 32'd0);
    if (kind == 3) chk(!mem_lock_o, "R6", "lock released", {31'd0, mem_lock_o}, 32'd0);
    for (int i = 0; i < 8; i++) chk(rf[i] === exp_rf[i], rq, $sformatf("reg %0d", i), rf[i], exp_rf[i]);
    if (kind == 3)
      for (int i = 0; i < 64; i++)
        if (mem[i] !== exp_mem[i]) chk(1'b0, "R5", $sformatf("mem byte %0d", i), {24'd0, mem[i]}, {24'd0, exp_mem[i]});
    if (intr) begin
      for (int k = 0; k < 3; k++) begin
        @(negedge clk);
        chk(!done_o && !busy_o, "R8", "start while busy ignored", {30'd0, done_o, busy_o}, 32'd0);
      end
    end
  endtask

  initial begin
    int t;
    t = 0;
    while (t < WATCHDOG) begin
      @(posedge clk);
      t++;
    end
    errors++;
    $display("FAIL watchdog: actual %0d cycles expected fewer", t);
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int form;
    logic [7:0] opc, mrm;
    logic o32;
    logic [5:0] ea;
    logic [31:0] snap [8];
    checks = 0; errors = 0;
    void'($urandom(32'd7321));
    rst_n = 1'b0; start_i = 1'b0; opcode_i = '0; modrm_i = '0; op32_i = 1'b0;
    eff_addr_i = '0; mem_ack_i = 1'b0; mem_rdata_i = '0; ld = 1'b0; ld_idx = '0; ld_val = '0;
    rand_ack = 1'b0; ack_wait = 0;
    for (int i = 0; i < 64; i++) mem[i] = 8'($urandom);
    repeat (3) @(negedge clk);
    chk(!busy_o && !done_o && !mem_req_o && !mem_lock_o && !rf_we0_o && !rf_we1_o, "R9",
        "reset state", {26'd0, busy_o, done_o, mem_req_o, mem_lock_o, rf_we0_o, rf_we1_o}, 32'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    for (int i = 0; i < 8; i++) load_reg(3'(i), 32'h1111_1111 * (i + 1) ^ 32'hA5C3_0F96);

    // Directed corner cases
    run_op(8'h90, 8'h00, 1'b0, 6'd0, 1'b0);   // R7 no-op, 16 bit
    run_op(8'h90, 8'h00, 1'b1, 6'd0, 1'b0);   // R7 no-op, 32 bit
    run_op(8'h97, 8'h00, 1'b0, 6'd0, 1'b0);   // R1 AX form keeps upper halves
    run_op(8'h93, 8'h00, 1'b1, 6'd0, 1'b0);   // R1 32-bit accumulator swap
    run_op(8'h86, 8'hE0, 1'b0, 6'd0, 1'b0);   // R2 high byte with low byte of reg 0
    run_op(8'h86, 8'hF1, 1'b1, 6'd0, 1'b0);   // R2 byte form ignores op32
    run_op(8'h87, 8'hDB, 1'b1, 6'd0, 1'b0);   // R7 self swap, reg form
    run_op(8'h87, 8'hCA, 1'b0, 6'd0, 1'b0);   // R3 16-bit reg form
    run_op(8'h87, 8'h15, 1'b1, 6'd8, 1'b0);   // R5 32-bit memory, zero-wait ack
    run_op(8'h86, 8'h65, 1'b0, 6'd13, 1'b0);  // R5 high byte to memory
    rand_ack = 1'b1;
    run_op(8'h87, 8'h8E, 1'b0, 6'd20, 1'b0);  // R5 16-bit memory, delayed acks
    run_op(8'h87, 8'h0F, 1'b1, 6'd32, 1'b1);  // R8 start while busy

    // R8 unknown opcode ignored
    for (int i = 0; i < 8; i++) snap[i] = rf[i];
    @(negedge clk);
    start_i = 1'b1; opcode_i = 8'h01; modrm_i = 8'hC1;
    @(negedge clk);
    start_i = 1'b0;
    for (int k = 0; k < 3; k++) begin
      chk(!busy_o && !done_o, "R8", "unknown opcode ignored", {30'd0, busy_o, done_o}, 32'd0);
      @(negedge clk);
    end
    for (int i = 0; i < 8; i++) chk(rf[i] === snap[i], "R8", "regs unchanged", rf[i], snap[i]);

    // Random mix
    for (int n = 0; n < 80; n++) begin
      form = int'($urandom % 3);
      o32  = 1'($urandom);
      mrm  = 8'($urandom);
      if ($urandom % 2 == 0) mrm[7:6] = 2'b11;
      opc  = (form == 0) ? {5'b10010, 3'($urandom)} : (form == 1) ? 8'h86 : 8'h87;
      if (form == 1)      ea = 6'($urandom % 64);
      else if (o32)       ea = 6'(($urandom % 16) * 4);
      else                ea = 6'(($urandom % 32) * 2);
      if (form == 2 && !o32 && mrm[7:6] != 2'b11) ea[0] = 1'b0;
      run_op(opc, mrm, o32, ea, 1'b0);
    end

    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule